// File: doc/BRIEF.md
# Interrupt Gate Dispatch Checker

This block decides how an interrupt or exception is delivered once its vector is known. A one-cycle `decide_i` strobe captures the vector, the current privilege level and whether the event came from a software interrupt instruction. The block then asks for the vector's gate entry over a simple request/ready lookup port. From the returned entry it classifies the gate as an interrupt gate, a trap gate or a task gate. It then applies the privilege rules.

The outcome is one of four result codes: enter the handler on the current stack, enter it with a stack switch to a more privileged level, request a task switch, or raise a general-protection fault. The result also reports the gate kind, the level at which the handler runs, whether further maskable interrupts must be blocked, and the vector concerned. These outputs are held until the consumer acknowledges them. The consumer may acknowledge and strobe the next event in the same cycle. Fetching segment descriptors, performing the task switch and building the stack frame belong to neighbouring logic.

Top module: `gate_dispatch_chk`

## Requirements
- R1: After reset neither `lk_req_o` nor `res_vld_o` is high. A `decide_i` pulse while idle makes `lk_req_o` high in the next cycle, with `lk_vec_o` equal to the sampled vector.
- R2: `lk_req_o` stays high with a stable `lk_vec_o` until a cycle in which `lk_rdy_i` is high. From the next cycle `res_vld_o` is high and `lk_req_o` is low.
- R3: The lookup word uses these fields: bit 0 present, bits 3:1 type (110 interrupt gate, 111 trap gate, 101 task gate), bits 5:4 gate level, bits 7:6 target code level, bit 8 conforming target. A non-present entry or any other type gives result code 3 (fault) and gate kind 3, with `res_vec_o` equal to the vector. The other result codes are 0 (same level), 1 (stack switch) and 2 (task switch). The other gate kinds are 0 (interrupt), 1 (trap) and 2 (task).
- R4: For a software event (`sw_event_i`=1), a current level numerically greater than the gate level gives code 3.
- R5: For hardware interrupts and exceptions (`sw_event_i`=0), the gate level has no effect on the result.
- R6: A valid task gate not faulted by R4 gives code 2, whatever its target level and conforming bit.
- R7: An interrupt or trap gate whose target level is numerically greater than the current level gives code 3, even when the target is conforming.
- R8: A conforming target with a level not above the current level gives code 0 and `new_pl_o` equal to the current level.
- R9: For a nonconforming target, a level below the current level gives code 1 and `new_pl_o` equal to the target level. An equal level gives code 0.
- R10: `mask_if_o` is 1 exactly when the code is 0 or 1 and the gate is an interrupt gate. For codes 2 and 3, `new_pl_o` equals the current level.
- R11: A `decide_i` pulse during a pending lookup, or while a result is held without `ack_i`, is ignored. Result outputs stay stable until `ack_i`.
- R12: `ack_i` alone returns the block to idle. `ack_i` together with `decide_i` drops `res_vld_o` and raises `lk_req_o` in the next cycle for the new vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| decide_i | input | 1 | One-cycle strobe starting a decision |
| vector_i | input | VEC_W | Interrupt or exception vector |
| cpl_i | input | 2 | Current privilege level |
| sw_event_i | input | 1 | Event raised by a software interrupt instruction |
| lk_req_o | output | 1 | Gate lookup request |
| lk_vec_o | output | VEC_W | Vector being looked up |
| lk_rdy_i | input | 1 | Lookup response valid |
| lk_desc_i | input | DESC_W | Gate entry returned by the lookup |
| res_vld_o | output | 1 | Result held and valid |
| res_code_o | output | 2 | Result code |
| gate_kind_o | output | 2 | Gate classification |
| new_pl_o | output | 2 | Level the handler runs at |
| mask_if_o | output | 1 | Block maskable interrupts on entry |
| res_vec_o | output | VEC_W | Vector the result belongs to |
| ack_i | input | 1 | Result consumed |

## Verification
Two of the block's functions can fall in the same cycle: release of a held result on `ack_i`, and acceptance of a new strobe on `decide_i`. A related collision occurs when a strobe arrives while the lookup is still pending. The bench drives `ack_i` and `decide_i` together in one cycle, and pulses `decide_i` both mid-lookup and mid-hold. Its reference model decides from the requirements whether each strobe is taken. Each clock, the bench compares the lookup vector, the valid flags and the held result fields against that model. A wrongly taken or wrongly dropped strobe therefore shows up as a vector or flag mismatch in the following cycle.

// File: rtl/gate_dispatch_pkg.sv
package gate_dispatch_pkg;

   localparam int PL_W      = 2;
   localparam int F_PRES    = 0;
   localparam int F_TY_LO   = 1;
   localparam int F_GPL_LO  = 4;
   localparam int F_TPL_LO  = 6;
   localparam int F_CONF    = 8;
   localparam int FIELD_TOP = F_CONF;

   localparam logic [2:0] TY_INTR = 3'b110;
   localparam logic [2:0] TY_TRAP = 3'b111;
   localparam logic [2:0] TY_TASK = 3'b101;

   typedef enum logic [1:0] {
      RES_SAME  = 2'd0,
      RES_STACK = 2'd1,
      RES_TASK  = 2'd2,
      RES_FAULT = 2'd3
   } res_e;

   typedef enum logic [1:0] {
      KIND_INTR = 2'd0,
      KIND_TRAP = 2'd1,
      KIND_TASK = 2'd2,
      KIND_NONE = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_DONE = 2'd2
   } st_e;

   typedef struct packed {
      logic            present;
      logic [2:0]      ty;
      logic [PL_W-1:0] gate_pl;
      logic [PL_W-1:0] tgt_pl;
      logic            conform;
   } gate_t;

endpackage

// File: rtl/gate_decode.sv
module gate_decode
   import gate_dispatch_pkg::*;
#(
   parameter int DESC_W = 16
) (
   input  logic [DESC_W-1:0] desc_i,
   output gate_t             gate_o,
   output kind_e             kind_o,
   output logic              ok_o
);

   if (DESC_W <= FIELD_TOP) begin : g_bad_width
      $error("gate_decode: DESC_W too small for the gate fields");
   end

   if (DESC_W > FIELD_TOP + 1) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^desc_i[DESC_W-1:FIELD_TOP+1];
   end

   assign gate_o.present = desc_i[F_PRES];
   assign gate_o.ty      = desc_i[F_TY_LO +: 3];
   assign gate_o.gate_pl = desc_i[F_GPL_LO +: PL_W];
   assign gate_o.tgt_pl  = desc_i[F_TPL_LO +: PL_W];
   assign gate_o.conform = desc_i[F_CONF];

   always_comb begin
      kind_o = KIND_NONE;
      if (gate_o.present) begin
         unique case (gate_o.ty)
            TY_INTR: kind_o = KIND_INTR;
            TY_TRAP: kind_o = KIND_TRAP;
            TY_TASK: kind_o = KIND_TASK;
            default: kind_o = KIND_NONE;
         endcase
      end
   end

   assign ok_o = (kind_o != KIND_NONE);

endmodule

// File: rtl/gate_judge.sv
module gate_judge
   import gate_dispatch_pkg::*;
(
   input  gate_t           gate_i,
   input  kind_e           kind_i,
   input  logic            ok_i,
   input  logic [PL_W-1:0] cpl_i,
   input  logic            sw_i,
   output res_e            res_o,
   output logic [PL_W-1:0] npl_o,
   output logic            mask_o
);

   logic sw_deny;
   logic tgt_up;
   logic tgt_down;

   // gate level only matters for software-issued events
   assign sw_deny  = sw_i && (cpl_i > gate_i.gate_pl);
   assign tgt_up   = gate_i.tgt_pl > cpl_i;
   assign tgt_down = gate_i.tgt_pl < cpl_i;

   always_comb begin
      res_o = RES_FAULT;
      npl_o = cpl_i;
      if (!ok_i || sw_deny) begin
         res_o = RES_FAULT;
      end else if (kind_i == KIND_TASK) begin
         res_o = RES_TASK;
      end else if (tgt_up) begin
         res_o = RES_FAULT;
      end else if (gate_i.conform || !tgt_down) begin
         res_o = RES_SAME;
      end else begin
         res_o = RES_STACK;
         npl_o = gate_i.tgt_pl;
      end
   end

   assign mask_o = (kind_i == KIND_INTR) && (res_o == RES_SAME || res_o == RES_STACK);

endmodule

// File: rtl/gate_dispatch_chk.sv
module gate_dispatch_chk
   import gate_dispatch_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int DESC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              decide_i,
   input  logic [VEC_W-1:0]  vector_i,
   input  logic [1:0]        cpl_i,
   input  logic              sw_event_i,
   output logic              lk_req_o,
   output logic [VEC_W-1:0]  lk_vec_o,
   input  logic              lk_rdy_i,
   input  logic [DESC_W-1:0] lk_desc_i,
   output logic              res_vld_o,
   output logic [1:0]        res_code_o,
   output logic [1:0]        gate_kind_o,
   output logic [1:0]        new_pl_o,
   output logic              mask_if_o,
   output logic [VEC_W-1:0]  res_vec_o,
   input  logic              ack_i
);

   if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vec
      $error("gate_dispatch_chk: VEC_W out of range");
   end

   st_e              st_q;
   logic [VEC_W-1:0] vec_q;
   logic [PL_W-1:0]  cpl_q;
   logic             sw_q;
   res_e             code_q;
   kind_e            kind_q;
   logic [PL_W-1:0]  npl_q;
   logic             mask_q;

   gate_t            d_gate;
   kind_e            d_kind;
   logic             d_ok;
   res_e             j_res;
   logic [PL_W-1:0]  j_npl;
   logic             j_mask;
   logic             take;

   gate_decode #(.DESC_W(DESC_W)) i_decode (
      .desc_i (lk_desc_i),
      .gate_o (d_gate),
      .kind_o (d_kind),
      .ok_o   (d_ok)
   );

   gate_judge i_judge (
      .gate_i (d_gate),
      .kind_i (d_kind),
      .ok_i   (d_ok),
      .cpl_i  (cpl_q),
      .sw_i   (sw_q),
      .res_o  (j_res),
      .npl_o  (j_npl),
      .mask_o (j_mask)
   );

   assign take = decide_i && ((st_q == ST_IDLE) || (st_q == ST_DONE && ack_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         vec_q  <= '0;
         cpl_q  <= '0;
         sw_q   <= 1'b0;
         code_q <= RES_SAME;
         kind_q <= KIND_NONE;
         npl_q  <= '0;
         mask_q <= 1'b0;
      end else begin
         if (take) begin
            st_q  <= ST_LOOK;
            vec_q <= vector_i;
            cpl_q <= cpl_i;
            sw_q  <= sw_event_i;
         end else begin
            unique case (st_q)
               ST_LOOK: if (lk_rdy_i) begin
                  st_q   <= ST_DONE;
                  code_q <= j_res;
                  kind_q <= d_kind;
                  npl_q  <= j_npl;
                  mask_q <= j_mask;
               end
               ST_DONE: if (ack_i) st_q <= ST_IDLE;
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign lk_req_o    = (st_q == ST_LOOK);
   assign lk_vec_o    = vec_q;
   assign res_vld_o   = (st_q == ST_DONE);
   assign res_code_o  = code_q;
   assign gate_kind_o = kind_q;
   assign new_pl_o    = npl_q;
   assign mask_if_o   = mask_q;
   assign res_vec_o   = vec_q;

   assert_lookup_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req_o && !lk_rdy_i |=> lk_req_o && $stable(lk_vec_o));

   assert_lookup_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req_o && lk_rdy_i |=> res_vld_o && !lk_req_o);

   assert_bad_gate_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o && gate_kind_o == KIND_NONE |-> res_code_o == RES_FAULT);

   assert_task_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o && gate_kind_o == KIND_TASK |-> res_code_o == RES_TASK || res_code_o == RES_FAULT);

   assert_stack_goes_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o && res_code_o == RES_STACK |-> new_pl_o < cpl_q);

   assert_mask_only_intr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o && mask_if_o |-> gate_kind_o == KIND_INTR && res_code_o != RES_FAULT && res_code_o != RES_TASK);

   assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o && !ack_i |=> res_vld_o && $stable(res_code_o) && $stable(new_pl_o) && $stable(res_vec_o));

   assert_back_to_back_R12: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o && ack_i && decide_i |=> lk_req_o && lk_vec_o == $past(vector_i));

endmodule

// File: tb/test_gate_dispatch_chk.sv
module test_gate_dispatch_chk;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        decide = 1'b0;
   logic [7:0]  vector = '0;
   logic [1:0]  cpl = '0;
   logic        sw = 1'b0;
   logic        lk_req;
   logic [7:0]  lk_vec;
   logic        lk_rdy = 1'b0;
   logic [15:0] lk_desc = '0;
   logic        res_vld;
   logic [1:0]  res_code;
   logic [1:0]  gate_kind;
   logic [1:0]  new_pl;
   logic        mask_if;
   logic [7:0]  res_vec;
   logic        ack = 1'b0;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   string cur_req = "R1";

   logic [15:0] tbl [0:255];
   int lat_cfg = 0;
   int rcnt = 0;

   // reference model state
   int m_st = 0;
   int m_vec = 0, m_cpl = 0;
   bit m_sw = 0;
   int e_code = 0, e_kind = 3, e_npl = 0, e_mask = 0;

   always #4 clk = ~clk;

   gate_dispatch_chk i_gate_dispatch_chk (
      .clk(clk), .rst_n(rst_n), .decide_i(decide), .vector_i(vector),
      .cpl_i(cpl), .sw_event_i(sw), .lk_req_o(lk_req), .lk_vec_o(lk_vec),
      .lk_rdy_i(lk_rdy), .lk_desc_i(lk_desc), .res_vld_o(res_vld),
      .res_code_o(res_code), .gate_kind_o(gate_kind), .new_pl_o(new_pl),
      .mask_if_o(mask_if), .res_vec_o(res_vec), .ack_i(ack)
   );

   function automatic logic [15:0] mk(bit p, int ty, int g, int t, bit c);
      logic [15:0] d;
      d = '0;
      d[0] = p; d[3:1] = 3'(ty); d[5:4] = 2'(g); d[7:6] = 2'(t); d[8] = c;
      return d;
   endfunction

   task automatic ref_decide(input logic [15:0] d, input int lvl, input bit s);
      int g, t;
      g = int'(d[5:4]); t = int'(d[7:6]);
      if (!d[0]) e_kind = 3;
      else if (d[3:1] == 3'b110) e_kind = 0;
      else if (d[3:1] == 3'b111) e_kind = 1;
      else if (d[3:1] == 3'b101) e_kind = 2;
      else e_kind = 3;
      e_npl = lvl; e_mask = 0;
      if (e_kind == 3) e_code = 3;
      else if (s && lvl > g) e_code = 3;
      else if (e_kind == 2) e_code = 2;
      else if (t > lvl) e_code = 3;
      else begin
         if (d[8] || t == lvl) e_code = 0;
         else begin e_code = 1; e_npl = t; end
         e_mask = (e_kind == 0) ? 1 : 0;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_st = 0;
      else begin
         case (m_st)
            0: if (decide) begin m_st = 1; m_vec = vector; m_cpl = cpl; m_sw = sw; end
            1: if (lk_rdy) begin ref_decide(lk_desc, m_cpl, m_sw); m_st = 2; end
            default: if (ack) begin
               if (decide) begin m_st = 1; m_vec = vector; m_cpl = cpl; m_sw = sw; end
               else m_st = 0;
            end
         endcase
      end
   end

   task automatic check(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      check(int'(lk_req), (m_st == 1) ? 1 : 0, "lk_req_o");
      check(int'(res_vld), (m_st == 2) ? 1 : 0, "res_vld_o");
      if (m_st == 1) check(int'(lk_vec), m_vec, "lk_vec_o");
      if (m_st == 2) begin
         check(int'(res_code), e_code, "res_code_o");
         check(int'(gate_kind), e_kind, "gate_kind_o");
         check(int'(new_pl), e_npl, "new_pl_o");
         check(int'(mask_if), e_mask, "mask_if_o");
         check(int'(res_vec), m_vec, "res_vec_o");
      end
   end

   // lookup responder
   always @(negedge clk) begin
      if (lk_req) begin
         if (rcnt >= lat_cfg) begin lk_rdy = 1'b1; lk_desc = tbl[lk_vec]; end
         else begin lk_rdy = 1'b0; lk_desc = '0; end
         rcnt++;
      end else begin
         rcnt = 0; lk_rdy = 1'b0; lk_desc = '0;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic wait_valid();
      int n;
      n = 0;
      while (!res_vld && n < 60) begin @(negedge clk); n++; end
      checks++;
      if (!res_vld) begin
         fails++;
         $display("FAIL %s result never valid: actual 0 expected 1", cur_req);
      end
   endtask

   task automatic run_one(input string tag, input int vec, input logic [15:0] d,
                          input int lvl, input bit s, input int lat, input int hold);
      cur_req = tag; tbl[vec] = d; lat_cfg = lat;
      @(negedge clk); decide = 1'b1; vector = 8'(vec); cpl = 2'(lvl); sw = s;
      @(negedge clk); decide = 1'b0;
      if (lat > 2) begin
         @(negedge clk); decide = 1'b1; vector = 8'(vec ^ 8'h55); cpl = 2'd0; sw = 1'b0;
         @(negedge clk); decide = 1'b0;
      end
      wait_valid();
      for (int i = 0; i < hold; i++) begin
         decide = 1'b1; vector = 8'(vec ^ 8'h0F);
         @(negedge clk); decide = 1'b0;
      end
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) tbl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 / R10: interrupt gate, stack switch
      run_one("R9",  8'h20, mk(1, 6, 3, 0, 0), 3, 0, 0, 0);
      run_one("R10", 8'h21, mk(1, 7, 3, 2, 0), 2, 0, 1, 0);
      run_one("R9",  8'h22, mk(1, 6, 0, 1, 0), 1, 0, 0, 0);
      // R7: target less privileged, also when conforming
      run_one("R7",  8'h30, mk(1, 6, 3, 3, 0), 1, 0, 0, 0);
      run_one("R7",  8'h31, mk(1, 7, 3, 2, 1), 0, 1, 1, 0);
      // R4 / R5: gate level with software and hardware sources
      run_one("R4",  8'h03, mk(1, 6, 0, 0, 0), 3, 1, 0, 0);
      run_one("R4",  8'h04, mk(1, 7, 3, 0, 0), 3, 1, 0, 0);
      run_one("R5",  8'h0E, mk(1, 6, 0, 0, 0), 3, 0, 1, 0);
      run_one("R5",  8'h0F, mk(1, 7, 1, 1, 0), 2, 0, 0, 0);
      // R6: task gates
      run_one("R6",  8'h08, mk(1, 5, 3, 0, 0), 3, 1, 0, 0);
      run_one("R6",  8'h09, mk(1, 5, 0, 3, 1), 0, 0, 1, 0);
      run_one("R4",  8'h0A, mk(1, 5, 1, 0, 0), 2, 1, 0, 0);
      // R8: conforming target
      run_one("R8",  8'h40, mk(1, 6, 3, 0, 1), 2, 0, 0, 0);
      run_one("R8",  8'h41, mk(1, 7, 3, 1, 1), 3, 1, 0, 0);
      // R3: absent or malformed entries
      run_one("R3",  8'h50, mk(0, 6, 3, 0, 0), 0, 0, 0, 0);
      run_one("R3",  8'h51, mk(1, 0, 3, 0, 0), 0, 0, 1, 0);
      run_one("R3",  8'hFF, mk(1, 4, 3, 0, 0), 2, 1, 0, 0);
      // R2 / R11: long lookups with a strobe during the lookup
      run_one("R2",  8'h60, mk(1, 6, 3, 1, 0), 3, 0, 4, 0);
      run_one("R11", 8'h61, mk(1, 7, 3, 0, 0), 2, 0, 3, 3);
      run_one("R11", 8'h62, mk(1, 6, 2, 2, 0), 2, 1, 0, 5);
      // R12: acknowledge and strobe in the same cycle
      cur_req = "R12";
      tbl[8'h70] = mk(1, 6, 3, 0, 0);
      tbl[8'h71] = mk(1, 5, 3, 0, 0);
      lat_cfg = 1;
      @(negedge clk); decide = 1'b1; vector = 8'h70; cpl = 2'd3; sw = 1'b0;
      @(negedge clk); decide = 1'b0;
      wait_valid();
      ack = 1'b1; decide = 1'b1; vector = 8'h71; cpl = 2'd1; sw = 1'b1;
      @(negedge clk); ack = 1'b0; decide = 1'b0;
      wait_valid();
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      // R1: idle after a plain acknowledge
      cur_req = "R1";
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule